// File: doc/BRIEF.md
# Accumulator Operate Microinstruction Unit

This block carries out the first group of operate microinstructions of a 12-bit minicomputer datapath. Each cycle it looks at an instruction word, the current accumulator and the one-bit link. When the strobe is high it registers the new accumulator and link that the instruction produces. Within a first-group word, several independent function bits may be set together. They are applied as a fixed sequence of steps: clearing first, then complementing, then incrementing, then one rotate or the half-word swap.

The sequencer that surrounds the block pulses the strobe for one cycle when an operate instruction is in the execute slot, and it then reads the registered result. A word that is not a first-group operate instruction is passed through unchanged. The caller can therefore strobe the block on every instruction without decoding it first.

The block does not define a result for a word that requests both rotate directions at once.

Top module: `acc_opr_unit`

## Requirements
- R1: The block recognises a word as a first-group operate instruction only when bits [11:8] are 1110 (binary). For any other word, a strobe latches the input accumulator and link unchanged.
- R2: Word 7000 (octal) has no function bits set. A strobe with it latches the input accumulator and link unchanged.
- R3: In step 1, bit 7 clears the accumulator and bit 6 clears the link. Word 7300 clears both.
- R4: In step 2, bit 5 complements the accumulator and bit 4 complements the link. Step 2 acts on the step-1 result, so 7240 yields 7777 and 7120 yields link 1.
- R5: In step 3, bit 0 adds one to the 13-bit value {link, accumulator}. A carry out of accumulator bit 11 complements the link. Step 3 acts on the step-2 result.
- R6: In step 4, bit 3 rotates the 13-bit ring {link, accumulator} right by one place, with accumulator bit 0 moving into the link. Bit 2 rotates the ring left by one place, with accumulator bit 11 moving into the link.
- R7: When bit 1 is set together with bit 3 or bit 2, the rotate distance in step 4 is two places.
- R8: Bit 1 set with neither rotate bit exchanges accumulator bits [11:6] and [5:0] in step 4, after the increment. The link is left unchanged.
- R9: Outputs change only on a clock edge where the strobe is high, and they hold otherwise. A synchronous reset drives both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Latch the result of the current word |
| instr_i | input | 12 | Instruction word |
| acc_i | input | 12 | Accumulator before the instruction |
| link_i | input | 1 | Link before the instruction |
| acc_o | output | 12 | Registered accumulator result |
| link_o | output | 1 | Registered link result |

## Verification
The bench targets the ordering corners. A design that complemented before clearing would return zero for 7240 rather than all ones. A design that incremented only 12 bits would leave the link alone when 7777 wraps to zero. A design that swapped or rotated before the increment would give wrong values for combined words such as 7003 and 7005. Rotates are tested with set bits at both ends of the ring, so a rotate that bypasses the link or loses the wrapped bit shows up. Words from other opcodes and the second operate group are applied to show that nothing there alters the data.

// File: rtl/opr_pkg.sv
package opr_pkg;

    localparam int WORD_W = 12;
    localparam int HALF_W = WORD_W / 2;
    localparam int RING_W = WORD_W + 1;

    // function bit positions within the operate word
    localparam int B_CLR_ACC  = 7;
    localparam int B_CLR_LNK  = 6;
    localparam int B_INV_ACC  = 5;
    localparam int B_INV_LNK  = 4;
    localparam int B_ROT_R    = 3;
    localparam int B_ROT_L    = 2;
    localparam int B_TWICE    = 1;
    localparam int B_INC      = 0;

    localparam logic [3:0] GRP1_CODE = 4'b1110;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_LEFT  = 2'd2,
        SH_SWAP  = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic        is_grp1;
        logic        clr_acc;
        logic        clr_lnk;
        logic        inv_acc;
        logic        inv_lnk;
        logic        inc;
        shift_kind_e shift;
        logic        twice;
    } opr_ctl_t;

    typedef struct packed {
        logic  lnk;
        word_t acc;
    } ring_t;

    function automatic ring_t ring_rot_right(input ring_t r);
        ring_t o;
        o.lnk = r.acc[0];
        o.acc = {r.lnk, r.acc[WORD_W-1:1]};
        return o;
    endfunction

    function automatic ring_t ring_rot_left(input ring_t r);
        ring_t o;
        o.lnk = r.acc[WORD_W-1];
        o.acc = {r.acc[WORD_W-2:0], r.lnk};
        return o;
    endfunction

endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import opr_pkg::*;
(
    input  word_t    instr_i,
    output opr_ctl_t ctl_o
);
    always_comb begin
        ctl_o.is_grp1 = (instr_i[WORD_W-1:WORD_W-4] == GRP1_CODE);
        ctl_o.clr_acc = instr_i[B_CLR_ACC];
        ctl_o.clr_lnk = instr_i[B_CLR_LNK];
        ctl_o.inv_acc = instr_i[B_INV_ACC];
        ctl_o.inv_lnk = instr_i[B_INV_LNK];
        ctl_o.inc     = instr_i[B_INC];
        ctl_o.twice   = instr_i[B_TWICE];
        // right rotate wins when both directions are requested (undefined case)
        if (instr_i[B_ROT_R])
            ctl_o.shift = SH_RIGHT;
        else if (instr_i[B_ROT_L])
            ctl_o.shift = SH_LEFT;
        else if (instr_i[B_TWICE])
            ctl_o.shift = SH_SWAP;
        else
            ctl_o.shift = SH_NONE;
    end
endmodule

// File: rtl/opr_arith.sv
module opr_arith
    import opr_pkg::*;
(
    input  opr_ctl_t ctl_i,
    input  ring_t    ring_i,
    output ring_t    ring_o
);
    ring_t after_clr;
    ring_t after_inv;

    // step 1: clears
    always_comb begin
        after_clr.acc = ctl_i.clr_acc ? '0 : ring_i.acc;
        after_clr.lnk = ctl_i.clr_lnk ? 1'b0 : ring_i.lnk;
    end

    // step 2: complements
    always_comb begin
        after_inv.acc = ctl_i.inv_acc ? ~after_clr.acc : after_clr.acc;
        after_inv.lnk = ctl_i.inv_lnk ? ~after_clr.lnk : after_clr.lnk;
    end

    // step 3: increment over the full ring, carry out of acc toggles link
    always_comb begin
        logic [WORD_W:0] sum;
        sum = {1'b0, after_inv.acc} + {{WORD_W{1'b0}}, ctl_i.inc};
        ring_o.acc = sum[WORD_W-1:0];
        ring_o.lnk = after_inv.lnk ^ sum[WORD_W];
    end
endmodule

// File: rtl/opr_shift.sv
module opr_shift
    import opr_pkg::*;
(
    input  opr_ctl_t ctl_i,
    input  ring_t    ring_i,
    output ring_t    ring_o
);
    ring_t rr1, rr2, rl1, rl2;
    word_t swapped;

    assign rr1 = ring_rot_right(ring_i);
    assign rr2 = ring_rot_right(rr1);
    assign rl1 = ring_rot_left(ring_i);
    assign rl2 = ring_rot_left(rl1);

    for (genvar gi = 0; gi < HALF_W; gi++) begin : g_swap
        assign swapped[gi]          = ring_i.acc[gi + HALF_W];
        assign swapped[gi + HALF_W] = ring_i.acc[gi];
    end

    // step 4: rotate or half swap
    always_comb begin
        unique case (ctl_i.shift)
            SH_RIGHT: ring_o = ctl_i.twice ? rr2 : rr1;
            SH_LEFT:  ring_o = ctl_i.twice ? rl2 : rl1;
            SH_SWAP:  ring_o = '{lnk: ring_i.lnk, acc: swapped};
            default:  ring_o = ring_i;
        endcase
    end
endmodule

// File: rtl/acc_opr_unit.sv
module acc_opr_unit
    import opr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic              link_i,
    output logic [WORD_W-1:0] acc_o,
    output logic              link_o
);
    opr_ctl_t ctl;
    ring_t    ring_in, ring_mid, ring_fin, ring_next;

    assign ring_in = '{lnk: link_i, acc: acc_i};

    opr_decode u_dec (
        .instr_i (instr_i),
        .ctl_o   (ctl)
    );

    opr_arith u_arith (
        .ctl_i  (ctl),
        .ring_i (ring_in),
        .ring_o (ring_mid)
    );

    opr_shift u_shift (
        .ctl_i  (ctl),
        .ring_i (ring_mid),
        .ring_o (ring_fin)
    );

    assign ring_next = ctl.is_grp1 ? ring_fin : ring_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o  <= '0;
            link_o <= 1'b0;
        end else if (strobe_i) begin
            acc_o  <= ring_next.acc;
            link_o <= ring_next.lnk;
        end
    end
endmodule

// File: rtl/acc_opr_chk.sv
module acc_opr_chk
    import opr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic              link_i,
    input  logic [WORD_W-1:0] acc_o,
    input  logic              link_o
);
    // R9
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (acc_o == '0) && !link_o);

    // R9
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(acc_o) && $stable(link_o));

    // R1
    foreign_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && instr_i[WORD_W-1:WORD_W-4] != GRP1_CODE)
        |=> (acc_o == $past(acc_i)) && (link_o == $past(link_i)));

    // R2
    nop_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && instr_i == 12'o7000)
        |=> (acc_o == $past(acc_i)) && (link_o == $past(link_i)));

    // R3
    clear_both_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && instr_i == 12'o7300) |=> (acc_o == '0) && !link_o);

    // R4
    clear_then_invert_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && instr_i == 12'o7240)
        |=> (acc_o == '1) && (link_o == $past(link_i)));

    // R8
    half_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && instr_i == 12'o7002)
        |=> (acc_o == {$past(acc_i[HALF_W-1:0]), $past(acc_i[WORD_W-1:HALF_W])})
            && (link_o == $past(link_i)));
endmodule

bind acc_opr_unit acc_opr_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe_i),
    .instr_i  (instr_i),
    .acc_i    (acc_i),
    .link_i   (link_i),
    .acc_o    (acc_o),
    .link_o   (link_o)
);

// File: tb/acc_opr_unit_tb.sv
module acc_opr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe_i = 1'b0;
    logic [11:0] instr_i = '0;
    logic [11:0] acc_i = '0;
    logic        link_i = 1'b0;
    logic [11:0] acc_o;
    logic        link_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    acc_opr_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe_i),
        .instr_i  (instr_i),
        .acc_i    (acc_i),
        .link_i   (link_i),
        .acc_o    (acc_o),
        .link_o   (link_o)
    );

    task automatic check(input string req, input logic [11:0] exp_acc, input logic exp_lnk);
        n_checks++;
        if (acc_o !== exp_acc || link_o !== exp_lnk) begin
            n_fail++;
            $display("FAIL %s: acc=%o link=%b expected acc=%o link=%b",
                     req, acc_o, link_o, exp_acc, exp_lnk);
        end
    endtask

    // drive one strobed word, then sample one cycle later away from the edge
    task automatic run_word(input string req, input logic [11:0] w, input logic [11:0] a,
                            input logic l, input logic [11:0] exp_acc, input logic exp_lnk);
        @(negedge clk);
        instr_i = w; acc_i = a; link_i = l; strobe_i = 1'b1;
        @(negedge clk);
        strobe_i = 1'b0;
        check(req, exp_acc, exp_lnk);
    endtask

    task automatic test_reset();
        check("R9 reset", 12'o0000, 1'b0);
    endtask

    task automatic test_decode();
        run_word("R1 memory ref", 12'o1234, 12'o5555, 1'b0, 12'o5555, 1'b0);
        run_word("R1 group two",  12'o7400, 12'o0123, 1'b1, 12'o0123, 1'b1);
        run_word("R1 io word",    12'o6001, 12'o7070, 1'b1, 12'o7070, 1'b1);
    endtask

    task automatic test_nop();
        run_word("R2 nop", 12'o7000, 12'o1234, 1'b1, 12'o1234, 1'b1);
    endtask

    task automatic test_clear();
        run_word("R3 clear acc",  12'o7200, 12'o7777, 1'b1, 12'o0000, 1'b1);
        run_word("R3 clear link", 12'o7100, 12'o1234, 1'b1, 12'o1234, 1'b0);
        run_word("R3 clear both", 12'o7300, 12'o4321, 1'b1, 12'o0000, 1'b0);
    endtask

    task automatic test_invert();
        run_word("R4 clear then invert", 12'o7240, 12'o1234, 1'b0, 12'o7777, 1'b0);
        run_word("R4 invert acc",        12'o7040, 12'o1234, 1'b0, 12'o6543, 1'b0);
        run_word("R4 invert link",       12'o7020, 12'o1234, 1'b0, 12'o1234, 1'b1);
        run_word("R4 clear then inv lnk",12'o7120, 12'o0000, 1'b1, 12'o0000, 1'b1);
    endtask

    task automatic test_increment();
        run_word("R5 plain inc",     12'o7001, 12'o0005, 1'b0, 12'o0006, 1'b0);
        run_word("R5 carry sets",    12'o7001, 12'o7777, 1'b0, 12'o0000, 1'b1);
        run_word("R5 carry clears",  12'o7001, 12'o7777, 1'b1, 12'o0000, 1'b0);
        run_word("R5 invert then inc",12'o7041,12'o0000, 1'b0, 12'o0000, 1'b1);
        run_word("R5 clear then inc",12'o7201, 12'o5555, 1'b0, 12'o0001, 1'b0);
    endtask

    task automatic test_rotate();
        run_word("R6 rar into link", 12'o7010, 12'o0001, 1'b0, 12'o0000, 1'b1);
        run_word("R6 ral into link", 12'o7004, 12'o4000, 1'b0, 12'o0000, 1'b1);
        run_word("R6 rar from link", 12'o7010, 12'o0002, 1'b1, 12'o4001, 1'b0);
        run_word("R6 ral from link", 12'o7004, 12'o0001, 1'b1, 12'o0003, 1'b0);
        run_word("R6 inc then ral",  12'o7005, 12'o7777, 1'b0, 12'o0001, 1'b0);
    endtask

    task automatic test_double();
        run_word("R7 rtr", 12'o7012, 12'o0001, 1'b0, 12'o4000, 1'b0);
        run_word("R7 rtl", 12'o7006, 12'o4000, 1'b0, 12'o0001, 1'b0);
        run_word("R7 rtl wrap", 12'o7006, 12'o2000, 1'b1, 12'o0002, 1'b1);
    endtask

    task automatic test_swap();
        run_word("R8 swap",          12'o7002, 12'o1234, 1'b1, 12'o3412, 1'b1);
        run_word("R8 inc then swap", 12'o7003, 12'o0077, 1'b0, 12'o0001, 1'b0);
    endtask

    task automatic test_hold_and_reset();
        run_word("R9 load", 12'o7000, 12'o2525, 1'b1, 12'o2525, 1'b1);
        @(negedge clk);
        instr_i = 12'o7300; acc_i = 12'o7777; link_i = 1'b0; strobe_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 hold without strobe", 12'o2525, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset mid run", 12'o0000, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_decode();
        test_nop();
        test_clear();
        test_invert();
        test_increment();
        test_rotate();
        test_double();
        test_swap();
        test_hold_and_reset();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(posedge clk);
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule